// File: doc/BRIEF.md
# Phase-Correct PWM Timer

This block is an up/down timer that builds a phase-correct pulse-width waveform on a single output. An 8-bit counter climbs from 0 to 0xFF and then falls back to 0, and it visits each end value for one tick only. A full period is therefore 510 timer ticks. A compare value is checked against the counter on every tick. When they match, the output is driven low or high. The direction depends on whether the counter is rising or falling, and on the two output-mode bits. A match also raises a sticky match flag, which is meant to feed an interrupt.

The timer does not advance on every system clock. It advances on a tick chosen by a three-bit clock selector. The selector can stop the timer, pass the system clock through undivided, or pick one of six taps from a free-running 10-bit prescaler. Software can load the counter directly. Such a load masks the compare on the following tick. New compare values are held in a buffer and copied into the active compare register only at the top of the count. The case where the compare value equals the top of the count is handled specially.

Top module: `pcpwm_timer`

## Requirements
- R1: After reset, the counter reads 0, the compare readback reads 0, the match flag is 0, and both `pwm_out` and `pwm_oe` are 0.
- R2: On each timer tick the counter steps by one. From 0 it always moves up and from 0xFF it always moves down, so one full sweep returns to 0 after exactly 510 ticks.
- R3: `clk_sel` code 0 stops the counter and code 1 ticks every system clock. Codes 2 to 7 tick once every 8, 32, 64, 128, 256 and 1024 system clocks, taken from a prescaler that free-runs from reset.
- R4: `out_mode` values 0b00 and 0b01 leave the pin undriven: `pwm_oe` is 0 and `pwm_out` is 0.
- R5: With `out_mode` 0b10, an unmasked match clears the level while rising and sets it while falling. Mode 0b11 does the opposite. A match at count 0 counts as rising. `pwm_oe` is 1 in both modes.
- R6: With undivided ticks and mode 0b10, one steady period holds `pwm_out` high for 0, 256 and 510 cycles at compare values 0x00, 0x80 and 0xFF. With mode 0b11 and compare value 0x80 it holds `pwm_out` high for 254 cycles.
- R7: A counter write masks any compare match on the next timer tick. The match flag and the output level are not changed by that tick.
- R8: A compare write is visible at once on `cmp_value` but takes effect only after the next tick at which the counter is 0xFF.
- R9: When the active compare value is 0xFF and `out_mode[1]` is 1, each tick at 0xFF applies the falling-slope action, even if the match is masked.
- R10: An unmasked match sets `match_flag`. A one-cycle `flag_clr` clears it, but a match in the same cycle wins.
- R11: A counter write takes priority over a tick in the same cycle. The direction of travel is kept across the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 3 | Tick source select |
| out_mode | input | 2 | Output action mode |
| cnt_wr_en | input | 1 | Counter load strobe |
| cnt_wr_data | input | 8 | Counter load value |
| cmp_wr_en | input | 1 | Compare buffer write strobe |
| cmp_wr_data | input | 8 | Compare buffer write value |
| flag_clr | input | 1 | Clear match flag |
| cnt_value | output | 8 | Current counter value |
| cmp_value | output | 8 | Compare buffer readback |
| pwm_out | output | 1 | Waveform output |
| pwm_oe | output | 1 | Output enable (timer drives pin) |
| match_flag | output | 1 | Sticky compare-match flag |

## Verification
The waveform is tried at compare values 0x00, 0x80 and 0xFF under both active modes. These values separate the always-low, balanced and always-high cases, and they show whether the boundary values land on the correct slope. All eight clock-select codes are swept, and the tick spacing is measured, so a wrong or swapped prescaler tap shows up. Counter loads at a matching value and one below it show the masking on a single tick. A load to 0xFF with a compare value of 0xFF isolates the top special case from ordinary matches. A compare write made in mid-period shows whether the double buffer defers the new value until the top of the count.

// File: rtl/pcpwm_pkg.sv
package pcpwm_pkg;

    localparam int CS_W     = 3;
    localparam int NUM_TAPS = 6;

    typedef enum logic [1:0] {
        OUT_OFF    = 2'b00,
        OUT_RSVD   = 2'b01,
        OUT_NONINV = 2'b10,
        OUT_INV    = 2'b11
    } out_mode_e;

    // number of low prescaler bits that must all be ones for tap idx
    function automatic int tap_log2(input int idx);
        case (idx)
            0:       return 3;
            1:       return 5;
            2:       return 6;
            3:       return 7;
            4:       return 8;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/pcpwm_prescaler.sv
module pcpwm_prescaler
    import pcpwm_pkg::*;
#(
    parameter int PRE_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [NUM_TAPS-1:0] taps_o
);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_st_t;

    pre_st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.pre = s_q.pre + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        localparam int LB = tap_log2(g);
        assign taps_o[g] = &s_q.pre[LB-1:0];
    end

    // R3
    tap_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taps_o[NUM_TAPS-1] |-> taps_o[0]);

    // R3
    tap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taps_o[0] |=> !taps_o[0]);

endmodule

// File: rtl/pcpwm_clksel.sv
module pcpwm_clksel
    import pcpwm_pkg::*;
(
    input  logic [CS_W-1:0]     cs_i,
    input  logic [NUM_TAPS-1:0] taps_i,
    output logic                tick_o
);

    always_comb begin
        tick_o = 1'b0;
        if (cs_i == CS_W'(1)) begin
            tick_o = 1'b1;
        end
        for (int k = 0; k < NUM_TAPS; k++) begin
            if (cs_i == CS_W'(k + 2)) tick_o = taps_i[k];
        end
    end

endmodule

// File: rtl/pcpwm_counter.sv
module pcpwm_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] cnt_o,
    output logic         dir_up_o,
    output logic         block_o
);

    localparam logic [W-1:0] TOP    = '1;
    localparam logic [W-1:0] BOTTOM = '0;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         up;
        logic         blk;
    } cnt_st_t;

    cnt_st_t s_d, s_q;
    logic    dir_up;

    always_comb begin
        // the end values force the turn; elsewhere the stored slope holds
        if (s_q.cnt == BOTTOM)   dir_up = 1'b1;
        else if (s_q.cnt == TOP) dir_up = 1'b0;
        else                     dir_up = s_q.up;

        s_d = s_q;
        if (wr_en_i) begin
            s_d.cnt = wr_data_i;
            s_d.blk = 1'b1;
        end else if (tick_i) begin
            s_d.cnt = dir_up ? s_q.cnt + 1'b1 : s_q.cnt - 1'b1;
            s_d.up  = dir_up;
            s_d.blk = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{cnt: '0, up: 1'b1, blk: 1'b0};
        else        s_q <= s_d;
    end

    assign cnt_o    = s_q.cnt;
    assign dir_up_o = dir_up;
    assign block_o  = s_q.blk;

    // R2
    top_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !wr_en_i && cnt_o == TOP) |=> (cnt_o == TOP - 1'b1));

    // R2
    bottom_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !wr_en_i && cnt_o == BOTTOM) |=> (cnt_o == BOTTOM + 1'b1));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !wr_en_i) |=> $stable(cnt_o));

    // R11
    wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (cnt_o == $past(wr_data_i)));

    // R7
    wr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> block_o);

endmodule

// File: rtl/pcpwm_wavegen.sv
module pcpwm_wavegen #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic [W-1:0] cnt_i,
    input  logic         dir_up_i,
    input  logic         block_i,
    input  logic [1:0]   mode_i,
    input  logic         cmp_wr_en_i,
    input  logic [W-1:0] cmp_wr_data_i,
    input  logic         flag_clr_i,
    output logic [W-1:0] cmp_buf_o,
    output logic         pwm_o,
    output logic         pwm_oe_o,
    output logic         flag_o
);

    localparam logic [W-1:0] TOP = '1;

    typedef struct packed {
        logic [W-1:0] cmp_buf;
        logic [W-1:0] cmp_act;
        logic         lvl;
        logic         flg;
    } wg_st_t;

    wg_st_t s_d, s_q;
    logic   top_tick;
    logic   hit;
    logic   top_case;

    always_comb begin
        top_tick = tick_i && (cnt_i == TOP);
        hit      = tick_i && (cnt_i == s_q.cmp_act) && !block_i;
        top_case = mode_i[1] && (s_q.cmp_act == TOP) && top_tick;

        s_d = s_q;
        if (mode_i[1]) begin
            if (top_case)  s_d.lvl = ~mode_i[0];
            else if (hit)  s_d.lvl = dir_up_i ? mode_i[0] : ~mode_i[0];
        end

        if (hit)             s_d.flg = 1'b1;
        else if (flag_clr_i) s_d.flg = 1'b0;

        if (top_tick)    s_d.cmp_act = s_q.cmp_buf;
        if (cmp_wr_en_i) s_d.cmp_buf = cmp_wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cmp_buf_o = s_q.cmp_buf;
    assign pwm_oe_o  = mode_i[1];
    assign pwm_o     = mode_i[1] & s_q.lvl;
    assign flag_o    = s_q.flg;

    // R7
    mask_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && block_i && !flag_o) |=> !flag_o);

    // R8
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick_i && cnt_i == TOP) |=> $stable(s_q.cmp_act));

    // R9
    top_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && cnt_i == TOP && s_q.cmp_act == TOP && mode_i == 2'b10)
        |=> s_q.lvl);

    // R4
    off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_i[1] |=> $stable(s_q.lvl));

endmodule

// File: rtl/pcpwm_timer.sv
module pcpwm_timer
    import pcpwm_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int PRE_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       clk_sel,
    input  logic [1:0]       out_mode,
    input  logic             cnt_wr_en,
    input  logic [CNT_W-1:0] cnt_wr_data,
    input  logic             cmp_wr_en,
    input  logic [CNT_W-1:0] cmp_wr_data,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt_value,
    output logic [CNT_W-1:0] cmp_value,
    output logic             pwm_out,
    output logic             pwm_oe,
    output logic             match_flag
);

    logic [NUM_TAPS-1:0] taps;
    logic                tick;
    logic                dir_up;
    logic                block;

    pcpwm_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .taps_o (taps)
    );

    pcpwm_clksel u_sel (
        .cs_i   (clk_sel),
        .taps_i (taps),
        .tick_o (tick)
    );

    pcpwm_counter #(.W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .wr_en_i   (cnt_wr_en),
        .wr_data_i (cnt_wr_data),
        .cnt_o     (cnt_value),
        .dir_up_o  (dir_up),
        .block_o   (block)
    );

    pcpwm_wavegen #(.W(CNT_W)) u_wg (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_i        (tick),
        .cnt_i         (cnt_value),
        .dir_up_i      (dir_up),
        .block_i       (block),
        .mode_i        (out_mode),
        .cmp_wr_en_i   (cmp_wr_en),
        .cmp_wr_data_i (cmp_wr_data),
        .flag_clr_i    (flag_clr),
        .cmp_buf_o     (cmp_value),
        .pwm_o         (pwm_out),
        .pwm_oe_o      (pwm_oe),
        .flag_o        (match_flag)
    );

    // R1
    reset_chk: assert property (@(posedge clk)
        !rst_n |=> (cnt_value == '0 && !match_flag && cmp_value == '0) || !rst_n);

endmodule

// File: tb/sim_pcpwm_timer.sv
module sim_pcpwm_timer;

    localparam time HALF = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] clk_sel = '0;
    logic [1:0] out_mode = '0;
    logic       cnt_wr_en = 1'b0;
    logic [7:0] cnt_wr_data = '0;
    logic       cmp_wr_en = 1'b0;
    logic [7:0] cmp_wr_data = '0;
    logic       flag_clr = 1'b0;
    logic [7:0] cnt_value, cmp_value;
    logic       pwm_out, pwm_oe, match_flag;

    int n_chk = 0;
    int n_fail = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;

    // behavioural reference state
    int m_pre, m_cnt, m_up, m_blk, m_buf, m_act, m_lvl, m_flg;

    always #HALF clk = ~clk;

    pcpwm_timer u0 (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .out_mode(out_mode),
        .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
        .cmp_wr_en(cmp_wr_en), .cmp_wr_data(cmp_wr_data), .flag_clr(flag_clr),
        .cnt_value(cnt_value), .cmp_value(cmp_value), .pwm_out(pwm_out),
        .pwm_oe(pwm_oe), .match_flag(match_flag)
    );

    function automatic int divf(int c);
        case (c)
            1: return 1;
            2: return 8;
            3: return 32;
            4: return 64;
            5: return 128;
            6: return 256;
            default: return 1024;
        endcase
    endfunction

    always @(posedge clk) begin : model
        int tk, du, hit, nl, nf, na, nb, nc, nu, nk;
        if (!rst_n) begin
            m_pre = 0; m_cnt = 0; m_up = 1; m_blk = 0;
            m_buf = 0; m_act = 0; m_lvl = 0; m_flg = 0;
        end else begin
            if (clk_sel == 0)      tk = 0;
            else if (clk_sel == 1) tk = 1;
            else                   tk = ((m_pre % divf(clk_sel)) == divf(clk_sel) - 1);
            du  = (m_cnt == 0) ? 1 : (m_cnt == 255) ? 0 : m_up;
            hit = tk && (m_cnt == m_act) && !m_blk;
            nl = m_lvl; nf = m_flg; na = m_act; nb = m_buf;
            nc = m_cnt; nu = m_up; nk = m_blk;
            if (out_mode[1]) begin
                if (tk && m_cnt == 255 && m_act == 255) nl = !out_mode[0];
                else if (hit) nl = du ? out_mode[0] : !out_mode[0];
            end
            if (hit) nf = 1; else if (flag_clr) nf = 0;
            if (tk && m_cnt == 255) na = m_buf;
            if (cmp_wr_en) nb = cmp_wr_data;
            if (cnt_wr_en) begin nc = cnt_wr_data; nk = 1; end
            else if (tk) begin nc = du ? m_cnt + 1 : m_cnt - 1; nu = du; nk = 0; end
            m_lvl = nl; m_flg = nf; m_act = na; m_buf = nb;
            m_cnt = nc; m_up = nu; m_blk = nk;
            m_pre = (m_pre + 1) % 1024;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(posedge clk) begin
        #8;
        if (mon_en && rst_n) begin
            chk("R2 counter vs model", cnt_value, m_cnt);
            chk("R5 pwm_out vs model", pwm_out, out_mode[1] ? m_lvl : 0);
            chk("R4 pwm_oe vs model", pwm_oe, out_mode[1]);
            chk("R10 flag vs model", match_flag, m_flg);
            chk("R8 cmp readback vs model", cmp_value, m_buf);
        end
    end

    task automatic cyc(int n);
        repeat (n) begin @(posedge clk); #5; end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic write_cmp(int v);
        cmp_wr_en = 1'b1; cmp_wr_data = 8'(v); cyc(1); cmp_wr_en = 1'b0;
    endtask

    task automatic write_cnt(int v);
        cnt_wr_en = 1'b1; cnt_wr_data = 8'(v); cyc(1); cnt_wr_en = 1'b0;
    endtask

    task automatic wait_cnt(int v);
        int n = 0;
        while (cnt_value != 8'(v) && n < 3000) begin cyc(1); n++; end
    endtask

    task automatic duty(string tag, int exp);
        int hi = 0;
        cyc(1100);
        for (int i = 0; i < 510; i++) begin
            if (pwm_out) hi++;
            cyc(1);
        end
        chk(tag, hi, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_up();
    end

    initial begin
        int prev, n;
        cyc(3);
        chk("R1 reset counter", cnt_value, 0);
        chk("R1 reset cmp", cmp_value, 0);
        chk("R1 reset flag", match_flag, 0);
        chk("R1 reset out", pwm_out, 0);
        chk("R1 reset oe", pwm_oe, 0);
        rst_n = 1'b1;
        mon_en = 1'b1;

        // R3: stopped
        cyc(1);
        prev = cnt_value;
        cyc(1500);
        chk("R3 stopped counter", cnt_value, prev);

        // R3: tick spacing per code
        for (int c = 1; c < 8; c++) begin
            clk_sel = 3'(c);
            cyc(1);
            prev = cnt_value; n = 0;
            while (cnt_value == 8'(prev) && n < 3000) begin cyc(1); n++; end
            prev = cnt_value; n = 0;
            while (cnt_value == 8'(prev) && n < 3000) begin cyc(1); n++; end
            chk($sformatf("R3 tick spacing code %0d", c), n, divf(c));
        end

        // R2: full sweep length and top reach
        clk_sel = 3'd1;
        wait_cnt(0);
        cyc(1);
        n = 1; prev = 0;
        while (cnt_value != 8'd0 && n < 3000) begin
            if (cnt_value > prev) prev = cnt_value;
            cyc(1); n++;
        end
        chk("R2 sweep length", n, 510);
        chk("R2 sweep peak", prev, 255);

        // R6/R5 duty cycles
        out_mode = 2'b10;
        write_cmp(8'h80); duty("R6 duty 0x80 mode10", 256);
        write_cmp(8'h00); duty("R6 duty 0x00 mode10", 0);
        write_cmp(8'hFF); duty("R6 duty 0xFF mode10", 510);
        out_mode = 2'b11;
        write_cmp(8'h80); duty("R6 duty 0x80 mode11", 254);

        // R4: disconnected modes
        out_mode = 2'b00; cyc(2);
        chk("R4 mode00 oe", pwm_oe, 0);
        duty("R4 mode00 out", 0);
        out_mode = 2'b01; cyc(2);
        chk("R4 mode01 oe", pwm_oe, 0);
        duty("R4 mode01 out", 0);

        // R8: compare buffer defers until top
        out_mode = 2'b10;
        write_cmp(8'h80); cyc(1100);
        wait_cnt(0); cyc(16);
        chk("R8 setup count", cnt_value, 16);
        write_cmp(8'h20);
        cyc(31);
        chk("R8 old compare still active", pwm_out, 1);
        chk("R8 readback", cmp_value, 8'h20);
        wait_cnt(0); cyc(48);
        chk("R8 new compare active", pwm_out, 0);

        // R7: counter write masks the next tick
        write_cmp(8'h40); cyc(1100);
        clk_sel = 3'd0; cyc(1);
        flag_clr = 1'b1; write_cnt(8'h40); flag_clr = 1'b0;
        clk_sel = 3'd1; cyc(1);
        chk("R7 masked match flag", match_flag, 0);
        chk("R7 count after masked tick", cnt_value, 8'h41);
        clk_sel = 3'd0; cyc(1);
        flag_clr = 1'b1; write_cnt(8'h3F); flag_clr = 1'b0;
        clk_sel = 3'd1; cyc(2);
        chk("R7 R10 unmasked match flag", match_flag, 1);
        flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
        chk("R10 flag cleared", match_flag, 0);

        // R11: write priority and kept direction
        wait_cnt(0); cyc(5);
        write_cnt(8'h90);
        chk("R11 write wins", cnt_value, 8'h90);
        cyc(1);
        chk("R11 rising kept", cnt_value, 8'h91);
        wait_cnt(255); cyc(5);
        write_cnt(8'h20);
        chk("R11 write wins falling", cnt_value, 8'h20);
        cyc(1);
        chk("R11 falling kept", cnt_value, 8'h1F);

        // R9: top special case with a masked tick
        out_mode = 2'b11;
        write_cmp(8'hFF); cyc(1100);
        clk_sel = 3'd0; cyc(1);
        out_mode = 2'b10;
        write_cnt(8'hFF);
        chk("R9 level before top tick", pwm_out, 0);
        clk_sel = 3'd1; cyc(1);
        chk("R9 level set at top", pwm_out, 1);

        cyc(2);
        finish_up();
    end

endmodule